// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides which hardware thread a multithreaded fetch stage serves in each of its fetch slots. Every cycle it looks at a status code per thread and at a mask of threads that are active, and it returns, for each fetch slot, a thread number and a valid flag. The fetch stage uses slot 0 first, then slot 1, and so on. Once a slot is invalid, the stage makes no further attempt that cycle.

Two policies are available. In single-thread mode only the lowest-numbered active thread is considered. In round-robin mode the block keeps an ordered list of thread numbers. Each slot scans the list from its head and grants the first thread that can fetch. That thread is then moved to the tail, so the next slot already sees the new order.

Grants are combinational from the current inputs and the stored order. The updated order is registered at the next clock edge. A pending drain request blocks all selection.

Top module: `tsel_thread_pick`

## Requirements
- R1: A thread can be granted only when its 3-bit status code is 0 (running), 1 (idle) or 4 (fill complete). Codes 2, 3, 5, 6 and 7 make the thread ineligible.
- R2: In round-robin mode, each slot grants the first eligible thread found when scanning the order list from its head. The granted thread moves to the tail, and the threads behind it each move up one position. The new order takes effect at the next rising clock edge.
- R3: After reset the order list is ascending, with thread 0 at the head and thread NT-1 at the tail.
- R4: When a slot finds no eligible thread it is invalid, every later slot in the same cycle is invalid too, and the order list is left as it was.
- R5: In single-thread mode only the lowest-numbered thread whose bit is set in `active_mask` is considered. If it is eligible, every slot grants it. Otherwise no slot is valid. The order list never changes in this mode.
- R6: Up to NS slots are granted per cycle in round-robin mode. Each slot scans the order as left by the slot before it, so a sole eligible thread fills every slot.
- R7: While `drain_req` is high, no slot is valid and the order list is unchanged.
- R8: A thread whose `active_mask` bit is 0 is never granted, whatever its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rr_mode | input | 1 | 1 = round-robin mode, 0 = single-thread mode |
| drain_req | input | 1 | Drain pending; blocks all grants |
| active_mask | input | NT | One bit per thread; 1 = thread takes part |
| thread_status | input | NT*3 | Status code of thread i in bits [3i+2:3i] |
| grant_valid | output | NS | Slot s holds a grant |
| grant_tid | output | NS*TIDW | Thread number granted to slot s, in bits [s*TIDW +: TIDW] |

## Verification
The bench drives every one of the eight status codes through single-thread mode. A design with a wrong eligibility decode would then grant a stalled thread, or refuse an idle one.

Round-robin sequences check that a thread which has been granted lands at the tail while the others keep their relative order. A pointer-rotation design would diverge from this once eligibility has gaps. The bench also checks that the second slot sees the order after the first slot's move; a design that reused the start-of-cycle order would grant the same thread twice when another thread was eligible.

Drain cycles, single-mode cycles and cycles with nothing eligible are each followed by round-robin cycles that expose the stored order. A design that let the order move in any of those cases would show a shifted grant sequence. A long pseudo-random run compares every slot against a queue model.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    localparam int STATUS_W = 3;

    typedef enum logic [STATUS_W-1:0] {
        ST_RUN        = 3'd0,
        ST_IDLE       = 3'd1,
        ST_SQUASH     = 3'd2,
        ST_STALL      = 3'd3,
        ST_FILL_DONE  = 3'd4,
        ST_WAIT_FILL  = 3'd5,
        ST_WAIT_RETRY = 3'd6,
        ST_TRAP       = 3'd7
    } thread_state_e;

    // R1: the three states from which a thread may take a fetch slot
    function automatic logic can_fetch(input logic [STATUS_W-1:0] code);
        return (code == ST_RUN) || (code == ST_IDLE) || (code == ST_FILL_DONE);
    endfunction

endpackage

// File: rtl/tsel_elig.sv
module tsel_elig
    import tsel_pkg::*;
#(
    parameter int NT = 4
) (
    input  logic [NT-1:0]          active_mask,
    input  logic [NT*STATUS_W-1:0] thread_status,
    output logic [NT-1:0]          elig
);

    for (genvar t = 0; t < NT; t++) begin : g_thr
        assign elig[t] = active_mask[t] && can_fetch(thread_status[t*STATUS_W +: STATUS_W]);
    end

endmodule

// File: rtl/tsel_first_active.sv
module tsel_first_active #(
    parameter int NT   = 4,
    parameter int TIDW = 2
) (
    input  logic [NT-1:0]   active_mask,
    output logic            found,
    output logic [TIDW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int t = NT - 1; t >= 0; t--) begin
            if (active_mask[t]) begin
                found = 1'b1;
                idx   = TIDW'(t);
            end
        end
    end

endmodule

// File: rtl/tsel_rr_slot.sv
module tsel_rr_slot #(
    parameter int NT   = 4,
    parameter int TIDW = 2
) (
    input  logic [NT*TIDW-1:0] order_in,
    input  logic [NT-1:0]      elig,
    output logic               hit,
    output logic [TIDW-1:0]    tid,
    output logic [NT*TIDW-1:0] order_out
);

    logic [TIDW-1:0] entry [NT];
    int unsigned     pos;

    for (genvar i = 0; i < NT; i++) begin : g_ent
        assign entry[i] = order_in[i*TIDW +: TIDW];
    end

    // scan from head
    always_comb begin
        hit = 1'b0;
        pos = 0;
        for (int i = 0; i < NT; i++) begin
            if (!hit && elig[entry[i]]) begin
                hit = 1'b1;
                pos = i;
            end
        end
        tid = entry[pos];
    end

    // move winner to tail, close the gap
    always_comb begin
        order_out = order_in;
        if (hit) begin
            for (int i = 0; i < NT; i++) begin
                if (i == NT - 1) begin
                    order_out[i*TIDW +: TIDW] = entry[pos];
                end else if (i >= int'(pos)) begin
                    order_out[i*TIDW +: TIDW] = entry[i+1];
                end
            end
        end
    end

endmodule

// File: rtl/tsel_thread_pick.sv
module tsel_thread_pick
    import tsel_pkg::*;
#(
    parameter int NT   = 4,
    parameter int NS   = 2,
    localparam int TIDW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rr_mode,
    input  logic                   drain_req,
    input  logic [NT-1:0]          active_mask,
    input  logic [NT*STATUS_W-1:0] thread_status,
    output logic [NS-1:0]          grant_valid,
    output logic [NS*TIDW-1:0]     grant_tid
);

    localparam int ORDER_W = NT * TIDW;

    function automatic logic [ORDER_W-1:0] ascending_order();
        logic [ORDER_W-1:0] o;
        o = '0;
        for (int i = 0; i < NT; i++) begin
            o[i*TIDW +: TIDW] = TIDW'(i);
        end
        return o;
    endfunction

    localparam logic [ORDER_W-1:0] RESET_ORDER = ascending_order();

    typedef struct packed {
        logic [ORDER_W-1:0] order;
    } sel_state_t;

    sel_state_t state_d, state_q;

    logic [NT-1:0]      elig;
    logic               first_found;
    logic [TIDW-1:0]    first_idx;
    logic [ORDER_W-1:0] order_chain [NS+1];
    logic [NS-1:0]      rr_hit;
    logic [NS-1:0]      rr_live;
    logic [NS*TIDW-1:0] rr_tid;

    tsel_elig #(.NT(NT)) u_elig (
        .active_mask  (active_mask),
        .thread_status(thread_status),
        .elig         (elig)
    );

    tsel_first_active #(.NT(NT), .TIDW(TIDW)) u_first (
        .active_mask(active_mask),
        .found      (first_found),
        .idx        (first_idx)
    );

    assign order_chain[0] = state_q.order;

    for (genvar s = 0; s < NS; s++) begin : g_slot
        tsel_rr_slot #(.NT(NT), .TIDW(TIDW)) u_slot (
            .order_in (order_chain[s]),
            .elig     (elig),
            .hit      (rr_hit[s]),
            .tid      (rr_tid[s*TIDW +: TIDW]),
            .order_out(order_chain[s+1])
        );
        if (s == 0) begin : g_head
            assign rr_live[s] = rr_hit[s];
        end else begin : g_tail
            assign rr_live[s] = rr_hit[s] && rr_live[s-1];
        end
    end

    // outputs
    always_comb begin
        grant_valid = '0;
        grant_tid   = '0;
        if (!drain_req) begin
            if (rr_mode) begin
                grant_valid = rr_live;
                grant_tid   = rr_tid;
            end else if (first_found && elig[first_idx]) begin
                grant_valid = '1;
                for (int s = 0; s < NS; s++) begin
                    grant_tid[s*TIDW +: TIDW] = first_idx;
                end
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (rr_mode && !drain_req) begin
            state_d.order = order_chain[NS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.order <= RESET_ORDER;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/tsel_thread_pick_chk.sv
module tsel_thread_pick_chk
    import tsel_pkg::*;
#(
    parameter int NT   = 4,
    parameter int NS   = 2,
    localparam int TIDW = (NT > 1) ? $clog2(NT) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rr_mode,
    input logic                   drain_req,
    input logic [NT-1:0]          active_mask,
    input logic [NT*STATUS_W-1:0] thread_status,
    input logic [NS-1:0]          grant_valid,
    input logic [NS*TIDW-1:0]     grant_tid,
    input logic [NT*TIDW-1:0]     order_q
);

    logic [TIDW-1:0] lowest_active;
    logic [TIDW-1:0] last_tid;

    always_comb begin
        lowest_active = '0;
        for (int t = NT - 1; t >= 0; t--) begin
            if (active_mask[t]) lowest_active = TIDW'(t);
        end
        last_tid = '0;
        for (int s = 0; s < NS; s++) begin
            if (grant_valid[s]) last_tid = grant_tid[s*TIDW +: TIDW];
        end
    end

    assert_drain_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req |-> (grant_valid == '0));

    assert_order_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_mode || drain_req || grant_valid == '0) |=> $stable(order_q));

    assert_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_mode && !drain_req && grant_valid[0])
        |=> (order_q[(NT-1)*TIDW +: TIDW] == $past(last_tid)));

    for (genvar s = 0; s < NS; s++) begin : g_slot
        assert_grant_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid[s] |->
            can_fetch(thread_status[grant_tid[s*TIDW +: TIDW]*STATUS_W +: STATUS_W]));

        assert_grant_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid[s] |-> active_mask[grant_tid[s*TIDW +: TIDW]]);

        assert_single_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!rr_mode && grant_valid[s]) |-> (grant_tid[s*TIDW +: TIDW] == lowest_active));

        if (s > 0) begin : g_chain
            assert_slot_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
                grant_valid[s] |-> grant_valid[s-1]);
        end
    end

endmodule

bind tsel_thread_pick tsel_thread_pick_chk #(.NT(NT), .NS(NS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rr_mode      (rr_mode),
    .drain_req    (drain_req),
    .active_mask  (active_mask),
    .thread_status(thread_status),
    .grant_valid  (grant_valid),
    .grant_tid    (grant_tid),
    .order_q      (state_q.order)
);

// File: tb/sim_tsel_thread_pick.sv
`timescale 1ns/100ps
module sim_tsel_thread_pick;

    localparam int NT   = 4;
    localparam int NS   = 2;
    localparam int TIDW = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                rr_mode = 1'b1;
    logic                drain_req = 1'b0;
    logic [NT-1:0]       active_mask = '0;
    logic [NT*3-1:0]     thread_status = '0;
    logic [NS-1:0]       grant_valid;
    logic [NS*TIDW-1:0]  grant_tid;

    int checks = 0;
    int fails  = 0;
    int q[$];
    bit exp_v [NS];
    int exp_t [NS];

    always #2.5 clk = ~clk;

    tsel_thread_pick #(.NT(NT), .NS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .drain_req(drain_req),
        .active_mask(active_mask), .thread_status(thread_status),
        .grant_valid(grant_valid), .grant_tid(grant_tid)
    );

    function automatic bit ok_code(int c);
        return (c == 0) || (c == 1) || (c == 4);
    endfunction

    // queue-based reference of R2, R4, R5, R6, R7, R8
    task automatic model(bit rr, bit dr, logic [NT-1:0] m, int st[NT]);
        for (int s = 0; s < NS; s++) begin
            exp_v[s] = 0;
            exp_t[s] = 0;
        end
        if (dr) return;
        if (!rr) begin
            int f = -1;
            for (int t = NT - 1; t >= 0; t--) if (m[t]) f = t;
            if (f >= 0 && ok_code(st[f]))
                for (int s = 0; s < NS; s++) begin
                    exp_v[s] = 1;
                    exp_t[s] = f;
                end
            return;
        end
        for (int s = 0; s < NS; s++) begin
            int k = -1;
            for (int i = q.size() - 1; i >= 0; i--)
                if (m[q[i]] && ok_code(st[q[i]])) k = i;
            if (k < 0) break;
            exp_v[s] = 1;
            exp_t[s] = q[k];
            q.delete(k);
            q.push_back(exp_t[s]);
        end
    endtask

    // one cycle: drive at negedge, compare 1 ns later, let the edge pass
    task automatic step(bit rr, bit dr, logic [NT-1:0] m, int st[NT], string tag);
        logic [NS-1:0]      ev;
        logic [NS*TIDW-1:0] et;
        bit bad;
        rr_mode     = rr;
        drain_req   = dr;
        active_mask = m;
        for (int t = 0; t < NT; t++) thread_status[t*3 +: 3] = 3'(st[t]);
        #1;
        model(rr, dr, m, st);
        bad = 0;
        ev  = '0;
        et  = '0;
        for (int s = 0; s < NS; s++) begin
            ev[s] = exp_v[s];
            et[s*TIDW +: TIDW] = TIDW'(exp_t[s]);
            if (grant_valid[s] !== exp_v[s]) bad = 1;
            else if (exp_v[s] && grant_tid[s*TIDW +: TIDW] !== TIDW'(exp_t[s])) bad = 1;
        end
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s: valid=%b tid=%h expected valid=%b tid=%h", tag,
                     grant_valid, grant_tid, ev, et);
        end
        @(negedge clk);
    endtask

    task automatic t_reset_order();
        int st[NT] = '{0, 0, 0, 0};
        step(1, 0, 4'hF, st, "R3 first grants after reset");
        step(1, 0, 4'hF, st, "R3 second cycle");
    endtask

    task automatic t_codes();
        for (int c = 0; c < 8; c++) begin
            int st[NT] = '{0, 3, 3, 3};
            st[0] = c;
            step(0, 0, 4'b0001, st, $sformatf("R1 code %0d", c));
        end
        begin
            int st[NT] = '{0, 0, 0, 0};
            step(1, 0, 4'hF, st, "R5 order untouched by single mode");
        end
    endtask

    task automatic t_skip();
        int st[NT] = '{3, 0, 7, 4};
        step(1, 0, 4'hF, st, "R2 skip ineligible");
        step(1, 0, 4'hF, st, "R2 skip ineligible again");
        st = '{1, 5, 0, 6};
        step(1, 0, 4'hF, st, "R2 other mix");
    endtask

    task automatic t_sole();
        int st[NT] = '{2, 2, 0, 2};
        step(1, 0, 4'hF, st, "R6 sole thread fills both slots");
    endtask

    task automatic t_none();
        int st[NT] = '{3, 5, 6, 7};
        step(1, 0, 4'hF, st, "R4 nothing eligible");
        st = '{0, 0, 0, 0};
        step(1, 0, 4'hF, st, "R4 order kept after empty cycle");
    endtask

    task automatic t_drain();
        int st[NT] = '{0, 0, 0, 0};
        step(1, 1, 4'hF, st, "R7 drain blocks");
        step(0, 1, 4'hF, st, "R7 drain blocks single mode");
        step(1, 0, 4'hF, st, "R7 order kept across drain");
    endtask

    task automatic t_mask();
        int st[NT] = '{0, 0, 0, 0};
        step(1, 0, 4'b1010, st, "R8 inactive skipped");
        step(1, 0, 4'b0000, st, "R8 none active");
        step(0, 0, 4'b0110, st, "R5 lowest active thread");
        st = '{0, 3, 0, 0};
        step(0, 0, 4'b0110, st, "R5 lowest active stalled");
        step(0, 0, 4'b0000, st, "R5 empty mask");
    endtask

    task automatic t_random();
        int unsigned seed = 32'h1234_5678;
        for (int n = 0; n < 80; n++) begin
            int st[NT];
            bit rr, dr;
            logic [NT-1:0] m;
            seed = seed * 1103515245 + 12345;
            for (int t = 0; t < NT; t++) st[t] = int'((seed >> (4 + 3*t)) & 7);
            m  = NT'(seed >> 20) | NT'(n % 5 == 0 ? 0 : 1);
            rr = ((seed >> 26) & 3) != 0;
            dr = ((seed >> 28) & 7) == 0;
            step(rr, dr, m, st, "R2 R6 random mix");
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        q = {0, 1, 2, 3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_order();
        t_codes();
        t_skip();
        t_sole();
        t_none();
        t_drain();
        t_mask();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule